// File: doc/BRIEF.md
# Pin Change Notification Interrupt Unit

This unit watches a port of digital input pins and drives one interrupt line for that port. The pins are first brought into the clock domain through a synchronizer chain. The unit then detects changes in one of two styles, chosen by a control bit.

In compare style, a pin is marked when its synchronized value differs from a stored reference. Reading the port data group copies the current pin values into that reference and clears every mark. In edge style, each pin has its own rising-edge enable and its own falling-edge enable. An enabled edge sets a sticky flag bit, and software clears that bit by writing a one to it.

Software reaches the unit through a word-addressed register bus with one-cycle read and write strobes. Each writable group has four alias words, selected by the two low address bits: 0 = plain write, 1 = clear the bits that are one, 2 = set the bits that are one, 3 = toggle the bits that are one. The group is selected by address bits [4:2]:

| Group | Contents |
|---|---|
| 0 | control |
| 1 | rising/compare enable |
| 2 | falling enable |
| 3 | compare status |
| 4 | edge flag |
| 5 | port data |

All higher address bits must be zero. The usual bring-up sequence is to clear both enable masks, write zero to control, set the on bit, and read the port once.

Top module: `pcn_port`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Control keeps only bit 15 (on), bit 13 (idle-stop, stored only) and bit 11 (style: 0 = compare, 1 = edge); all other control bits read zero. Alias words clear, set or toggle only the bits written as one. The pin masks keep the low NPINS bits.
- R3: A read returns data in `bus_rdata` one cycle after the strobe. A port data read returns the synchronized pins, which lag the input pins by SYNC_STAGES cycles.
- R4: In compare style with the unit on, a status bit is set and stays set when its synchronized pin differs from the reference. `irq_o` is high when status AND the rising/compare enable mask is nonzero, and it is visible 3 cycles after the pin changes.
- R5: A port data read loads the reference with the synchronized pins and clears all status bits, so `irq_o` falls.
- R6: In edge style, a rising edge on a pin whose rising enable is set sets that pin's flag bit within 3 cycles.
- R7: In edge style, a falling edge on a pin whose falling enable is set sets that pin's flag bit.
- R8: An edge in a direction that is not enabled for that pin sets no flag bit.
- R9: Writing a mask to the flag clear alias (group 4, alias 1) clears those flag bits. `irq_o` then drops if no other flag bit is pending.
- R10: When an enabled edge and a clear of the same flag bit fall in the same cycle, the flag bit ends up set.
- R11: With the on bit at zero, no status or flag bit is set, `irq_o` stays low, and the register contents are kept.
- R12: Reads of groups 6 and 7, and of any address with a high bit set, return zero. Writes to the status and port data groups have no effect.
- R13: In edge style, `irq_o` is high exactly when flag AND (rising enable OR falling enable) is nonzero, so clearing an enable masks a flag that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | AW | Word address: group [4:2], alias [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Port change interrupt |

## Verification
Faults in the synchronizer or the reference register show up as wrong port data or wrong status on the first read made after a pin change. `irq_o` settles three cycles after that change. A flag or status bit that is stuck, lost or set on the wrong pin appears in the next flag or status read as a bit other than the one-hot value expected for the swept pin. A wrong priority between clear and set appears only in the single-cycle collision test, as a zero read back from the flag group.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ALIAS_W  = 2;
  localparam int unsigned GRP_W    = 3;
  localparam int unsigned ON_BIT   = 15;
  localparam int unsigned IDLE_BIT = 13;
  localparam int unsigned EDGE_BIT = 11;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (32'd1 << ON_BIT) | (32'd1 << IDLE_BIT) | (32'd1 << EDGE_BIT);

  typedef enum logic [ALIAS_W-1:0] {
    AL_WRITE = 2'd0,
    AL_CLR   = 2'd1,
    AL_SET   = 2'd2,
    AL_INV   = 2'd3
  } alias_e;

  localparam logic [GRP_W-1:0] GRP_CTRL = 3'd0;
  localparam logic [GRP_W-1:0] GRP_RISE = 3'd1;
  localparam logic [GRP_W-1:0] GRP_FALL = 3'd2;
  localparam logic [GRP_W-1:0] GRP_STAT = 3'd3;
  localparam logic [GRP_W-1:0] GRP_FLAG = 3'd4;
  localparam logic [GRP_W-1:0] GRP_PORT = 3'd5;
endpackage

// File: rtl/pcn_alias_reg.sv
module pcn_alias_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  pcn_pkg::alias_e op,
  input  logic [W-1:0]    wdata,
  input  logic [W-1:0]    hw_set,
  output logic [W-1:0]    q
);
  import pcn_pkg::*;

  logic [W-1:0] sw_val;
  logic [W-1:0] nxt;

  always_comb begin
    unique case (op)
      AL_WRITE: sw_val = wdata;
      AL_CLR:   sw_val = q & ~wdata;
      AL_SET:   sw_val = q | wdata;
      default:  sw_val = q ^ wdata;
    endcase
    nxt = wr_en ? ((sw_val & WMASK) | (q & ~WMASK)) : q;
  end

  // hardware set is applied after the software update, so a set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt | (hw_set & WMASK);
  end
endmodule

// File: rtl/pcn_sync.sv
module pcn_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= {stg_q[STAGES-2:0], pins_i};
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = sync_o & ~prev_q;
  assign fall_o = ~sync_o & prev_q;
endmodule

// File: rtl/pcn_detect.sv
module pcn_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         on_i,
  input  logic         edge_i,
  input  logic         port_rd_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] pos_en_i,
  input  logic [W-1:0] neg_en_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] flag_set_o
);
  logic [W-1:0] ref_q;

  for (genvar p = 0; p < W; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q[p]  <= 1'b0;
        stat_o[p] <= 1'b0;
      end else if (port_rd_i) begin
        ref_q[p]  <= sync_i[p];
        stat_o[p] <= 1'b0;
      end else if (on_i && !edge_i && (sync_i[p] != ref_q[p])) begin
        stat_o[p] <= 1'b1;
      end
    end

    assign flag_set_o[p] = on_i && edge_i &&
                           ((rise_i[p] && pos_en_i[p]) || (fall_i[p] && neg_en_i[p]));
  end
endmodule

// File: rtl/pcn_port.sv
module pcn_port #(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned AW          = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPINS-1:0]           pins_i,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [pcn_pkg::DATA_W-1:0] bus_wdata,
  output logic [pcn_pkg::DATA_W-1:0] bus_rdata,
  output logic                       irq_o
);
  import pcn_pkg::*;

  localparam int unsigned DEC_W = ALIAS_W + GRP_W;

  logic [GRP_W-1:0]  grp;
  alias_e            op;
  logic              in_range;
  logic              wr_ctrl, wr_rise, wr_fall, wr_flag, port_rd;
  logic [DATA_W-1:0] ctrl_q;
  logic [NPINS-1:0]  pos_q, neg_q, flag_q, stat_q, flag_set;
  logic [NPINS-1:0]  sync_v, rise_v, fall_v;
  logic              mod_on, edge_mode;

  assign grp      = bus_addr[DEC_W-1:ALIAS_W];
  assign op       = alias_e'(bus_addr[ALIAS_W-1:0]);
  assign in_range = (bus_addr >> DEC_W) == '0;

  assign wr_ctrl = bus_wr && in_range && (grp == GRP_CTRL);
  assign wr_rise = bus_wr && in_range && (grp == GRP_RISE);
  assign wr_fall = bus_wr && in_range && (grp == GRP_FALL);
  assign wr_flag = bus_wr && in_range && (grp == GRP_FLAG);
  assign port_rd = bus_rd && in_range && (grp == GRP_PORT);

  pcn_alias_reg #(.W(DATA_W), .WMASK(CTRL_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .op(op),
    .wdata(bus_wdata), .hw_set('0), .q(ctrl_q));

  pcn_alias_reg #(.W(NPINS)) u_pos (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_rise), .op(op),
    .wdata(bus_wdata[NPINS-1:0]), .hw_set('0), .q(pos_q));

  pcn_alias_reg #(.W(NPINS)) u_neg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fall), .op(op),
    .wdata(bus_wdata[NPINS-1:0]), .hw_set('0), .q(neg_q));

  pcn_alias_reg #(.W(NPINS)) u_flag (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_flag), .op(op),
    .wdata(bus_wdata[NPINS-1:0]), .hw_set(flag_set), .q(flag_q));

  assign mod_on    = ctrl_q[ON_BIT];
  assign edge_mode = ctrl_q[EDGE_BIT];

  pcn_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
    .sync_o(sync_v), .rise_o(rise_v), .fall_o(fall_v));

  pcn_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .on_i(mod_on), .edge_i(edge_mode),
    .port_rd_i(port_rd), .sync_i(sync_v), .rise_i(rise_v), .fall_i(fall_v),
    .pos_en_i(pos_q), .neg_en_i(neg_q), .stat_o(stat_q), .flag_set_o(flag_set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!in_range) begin
        bus_rdata <= '0;
      end else begin
        unique case (grp)
          GRP_CTRL: bus_rdata <= ctrl_q;
          GRP_RISE: bus_rdata <= DATA_W'(pos_q);
          GRP_FALL: bus_rdata <= DATA_W'(neg_q);
          GRP_STAT: bus_rdata <= DATA_W'(stat_q);
          GRP_FLAG: bus_rdata <= DATA_W'(flag_q);
          GRP_PORT: bus_rdata <= DATA_W'(sync_v);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assign irq_o = mod_on && (edge_mode ? |(flag_q & (pos_q | neg_q))
                                      : |(stat_q & pos_q));
endmodule

// File: rtl/pcn_port_chk.sv
module pcn_port_chk #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             irq_o,
  input logic [31:0]      ctrl_q,
  input logic [NPINS-1:0] pos_q,
  input logic [NPINS-1:0] neg_q,
  input logic [NPINS-1:0] flag_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] rise_v
);
  logic       ok_range;
  logic [2:0] g;
  logic       on, edge_sel;
  assign ok_range = (bus_addr >> 5) == '0;
  assign g        = bus_addr[4:2];
  assign on       = ctrl_q[15];
  assign edge_sel = ctrl_q[11];

  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !irq_o);

  p_unimpl_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (!ok_range || g > 3'd5)) |=> (bus_rdata == 32'd0));

  p_port_read_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ok_range && g == 3'd5) |=> (stat_q == '0));

  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && ok_range && g == 3'd5) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (on && edge_sel && |(rise_v & pos_q))
      |=> ((flag_q & $past(rise_v & pos_q)) == $past(rise_v & pos_q)));

  p_flag_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && ok_range && g == 3'd4)
      |=> (((flag_q & ~$past(flag_q)) & ~($past(pos_q) | $past(neg_q))) == '0));
endmodule

bind pcn_port pcn_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .ctrl_q(ctrl_q), .pos_q(pos_q), .neg_q(neg_q), .flag_q(flag_q),
  .stat_q(stat_q), .rise_v(rise_v));

// File: tb/sim_pcn_port.sv
`timescale 1ns/1ps
module sim_pcn_port;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [31:0] rv;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pcn_port #(.NPINS(NP), .AW(6), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq));

  function automatic logic [5:0] ad(input int grp, input int al);
    return 6'((grp << 2) | al);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; rv = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] refv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(ad(0,0)); chk("R1 ctrl", rv, 0);
    rd(ad(1,0)); chk("R1 rise en", rv, 0);
    rd(ad(4,0)); chk("R1 flag", rv, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 aliases
    wr(ad(0,0), 32'hFFFF_FFFF); rd(ad(0,0)); chk("R2 ctrl mask", rv, 32'hA800);
    wr(ad(0,1), 32'h8000);      rd(ad(0,0)); chk("R2 ctrl clr", rv, 32'h2800);
    wr(ad(0,3), 32'h0800);      rd(ad(0,0)); chk("R2 ctrl inv", rv, 32'h2000);
    wr(ad(0,2), 32'h8800);      rd(ad(0,0)); chk("R2 ctrl set", rv, 32'hA800);
    wr(ad(1,0), 32'hFFFF_00F0); rd(ad(1,0)); chk("R2 en write", rv, 32'h00F0);
    wr(ad(1,2), 32'h0003);      rd(ad(1,0)); chk("R2 en set", rv, 32'h00F3);
    wr(ad(1,1), 32'h0010);      rd(ad(1,0)); chk("R2 en clr", rv, 32'h00E3);
    wr(ad(1,3), 32'h0101);      rd(ad(1,0)); chk("R2 en inv", rv, 32'h01E2);

    // bring-up
    wr(ad(1,1), 32'hFFFF); wr(ad(2,1), 32'hFFFF);
    wr(ad(0,0), 0); wr(ad(0,2), 32'h8000);
    rd(ad(5,0)); refv = 0;

    // R3 R4 R5 compare-style sweep
    wr(ad(1,0), 32'hFFFF);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk); pins = NP'(1 << i);
      settle();
      chk("R4 irq raised", 32'(irq), 1);
      rd(ad(3,0)); chk("R4 status", rv, (32'(1) << i) ^ refv);
      rd(ad(5,0)); chk("R3 port data", rv, 32'(1) << i);
      refv = 32'(1) << i;
      settle();
      rd(ad(3,0)); chk("R5 status cleared", rv, 0);
      chk("R5 irq dropped", 32'(irq), 0);
    end
    // R4 enable mask gates irq
    wr(ad(1,0), 32'h0001);
    @(negedge clk); pins = 16'h8020; settle();
    rd(ad(3,0)); chk("R4 masked status", rv, 32'h0020);
    chk("R4 masked irq", 32'(irq), 0);
    @(negedge clk); pins = 16'h8021; settle();
    chk("R4 unmasked irq", 32'(irq), 1);
    rd(ad(5,0));

    // R11 unit off
    wr(ad(0,1), 32'h8000);
    @(negedge clk); pins = 16'h00FF; settle();
    chk("R11 irq off", 32'(irq), 0);
    rd(ad(3,0)); chk("R11 no status", rv, 0);
    rd(ad(1,0)); chk("R11 kept", rv, 32'h0001);
    @(negedge clk); pins = '0; settle();

    // edge style
    wr(ad(0,2), 32'h8800);
    wr(ad(1,0), 0); wr(ad(2,0), 0); wr(ad(4,1), 32'hFFFF);
    for (int i = 0; i < NP; i++) begin
      wr(ad(1,0), 32'(1) << i); wr(ad(2,0), 0);
      @(negedge clk); pins = NP'(1 << i); settle();
      rd(ad(4,0)); chk("R6 rise flag", rv, 32'(1) << i);
      chk("R6 irq", 32'(irq), 1);
      wr(ad(4,1), 32'(1) << i);
      rd(ad(4,0)); chk("R9 flag cleared", rv, 0);
      chk("R9 irq dropped", 32'(irq), 0);
      @(negedge clk); pins = '0; settle();
      rd(ad(4,0)); chk("R8 fall not enabled", rv, 0);
      wr(ad(1,0), 0); wr(ad(2,0), 32'(1) << i);
      @(negedge clk); pins = NP'(1 << i); settle();
      rd(ad(4,0)); chk("R8 rise not enabled", rv, 0);
      @(negedge clk); pins = '0; settle();
      rd(ad(4,0)); chk("R7 fall flag", rv, 32'(1) << i);
      chk("R7 irq", 32'(irq), 1);
      wr(ad(4,1), 32'(1) << i);
      rd(ad(4,0)); chk("R9 fall cleared", rv, 0);
    end

    // R13 irq uses enables
    wr(ad(2,0), 0); wr(ad(1,0), 1);
    @(negedge clk); pins = 16'h0001; settle();
    wr(ad(1,0), 0);
    chk("R13 masked irq", 32'(irq), 0);
    rd(ad(4,0)); chk("R13 flag kept", rv, 1);
    wr(ad(2,0), 1);
    chk("R13 falling enable counts", 32'(irq), 1);
    wr(ad(4,1), 1); wr(ad(2,0), 0);
    @(negedge clk); pins = '0; settle();

    // R10 set wins over clear
    wr(ad(1,0), 1);
    @(negedge clk); pins = 16'h0001; settle();
    @(negedge clk); pins = '0; settle();
    rd(ad(4,0)); chk("R10 pre flag", rv, 1);
    @(negedge clk); pins = 16'h0001;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = ad(4,1); bus_wdata = 1;
    @(negedge clk); bus_wr = 1'b0;
    rd(ad(4,0)); chk("R10 set wins", rv, 1);
    wr(ad(4,1), 1);
    rd(ad(4,0)); chk("R9 later clear", rv, 0);

    // R12 unimplemented and read-only
    @(negedge clk); pins = 16'h0003; settle();
    rd(ad(6,0)); chk("R12 group 6", rv, 0);
    rd(ad(7,3)); chk("R12 group 7", rv, 0);
    rd(6'h20);   chk("R12 high addr", rv, 0);
    wr(ad(3,0), 32'hFFFF); rd(ad(3,0)); chk("R12 status write ignored", rv, 0);
    wr(ad(5,0), 32'hFFFF); rd(ad(5,0)); chk("R12 port write ignored", rv, 32'h0003);

    summary();
  end
endmodule